// File: doc/BRIEF.md
# Pin-Change Wake Port Controller

This block is the configuration and wake logic of a small general-purpose I/O port in a microcontroller-style core. It holds a direction bit for each pin and three global control bits. Two of those bits are active-low: one enables weak pull-ups and one enables wake-up on pin change. The third selects the external timer clock source. From these it drives a per-pin output enable and a per-pin pull-up enable. While the core sleeps, it watches the synchronised pin levels and raises a wake strobe.

On reset, every pin is an input and every global bit is 1. Pull-ups and wake-up therefore start disabled. A pin's direction bit overrides the global pull-up and wake enables: a pin driven as an output never gets a pull-up and never wakes the core. When the timer clock-source bit is set, pin 2 is held as an input whatever its direction bit says. The sleep controller raises `sleep` to enter sleep. On that edge the block records the pin levels. The first difference on an enabled pin then produces a one-cycle `wake` pulse.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset all direction bits are 1 (input) and the three global bits are 1. `pin_oe` and `pin_pu_en` are all 0 and `wake` is 0.
- R2: A cycle with `dir_we`=1 loads `dir_wdata` into the direction bits, with bit i controlling pin i. From the next cycle on, `pin_oe[i]` is the inverse of direction bit i for every pin except the timer pin.
- R3: While the timer clock-source bit is 1, `pin_oe[2]` is 0 regardless of direction bit 2. While it is 0, pin 2 follows its direction bit. The global bits load from `opt_*` on a cycle with `opt_we`=1.
- R4: `pin_pu_en[i]` is 1 only when all three of these hold: pin i is one of pins 0, 1 and 3; its direction bit is 1; and the pull-up control bit is 0 (0 = enabled). Pins 2, 4 and 5 never get a pull-up.
- R5: A pin whose direction bit is 0 has neither a pull-up nor wake-on-change, whatever the global bits say. `pin_oe` and `pin_pu_en` are never both 1 on the same pin.
- R6: Each pin passes through a two-flop synchroniser. On the first cycle that `sleep` is 1, the synchronised levels are recorded. A change on an enabled pin raises `wake` two clock edges after the change is applied at `pin_in`.
- R7: `wake` is a one-cycle pulse. Further changes during the same sleep period produce no further pulse. Dropping `sleep` re-arms the detector.
- R8: Wake-on-change applies only to pins 0, 1 and 3, with direction bit 1, and only when the wake control bit is 0 (0 = enabled). A change on any other pin, or with the wake bit at 1, leaves `wake` at 0.
- R9: While `sleep` is 0, `wake` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_we | input | 1 | Load direction bits |
| dir_wdata | input | 6 | New direction bits, 1 = input |
| opt_we | input | 1 | Load global control bits |
| opt_wake_off | input | 1 | 1 disables wake-on-change |
| opt_pull_off | input | 1 | 1 disables weak pull-ups |
| opt_tsrc | input | 1 | 1 forces pin 2 to input (timer clock source) |
| sleep | input | 1 | High while the core sleeps |
| pin_in | input | 6 | Asynchronous pin levels |
| pin_oe | output | 6 | Per-pin output enable |
| pin_pu_en | output | 6 | Per-pin weak pull-up enable |
| wake | output | 1 | One-cycle wake request |

## Verification
The assertions assume three things about the inputs: `sleep` is a level held for many cycles, each configuration write is a single-cycle pulse with its data stable in that cycle, and pin changes are slow compared with the clock. The bench drives every input half a cycle away from the active edge. It holds `sleep` for at least several cycles. During sleep it changes a pin only after the snapshot has been taken, so that each wake check refers to a known snapshot.

// File: rtl/gpio_wake_port.sv
module gpio_wake_port #(
  parameter int         N         = 6,
  parameter logic [5:0] FEAT_MASK = 6'b001011,
  parameter int         TMR_PIN   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic [N-1:0] dir_wdata,
  input  logic         opt_we,
  input  logic         opt_wake_off,
  input  logic         opt_pull_off,
  input  logic         opt_tsrc,
  input  logic         sleep,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_pu_en,
  output logic         wake
);

  localparam logic [N-1:0] MASK  = FEAT_MASK[N-1:0];
  localparam logic [N-1:0] FORCE = N'(1) << TMR_PIN;

  logic [N-1:0] dir_q, sync1, sync2, snap;
  logic         wake_off_q, pull_off_q, tsrc_q;
  logic         sleep_q, seen_q;
  logic [N-1:0] wk_en;
  logic         diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= '1;
      wake_off_q <= 1'b1;
      pull_off_q <= 1'b1;
      tsrc_q     <= 1'b1;
    end else begin
      if (dir_we) dir_q <= dir_wdata;
      if (opt_we) begin
        wake_off_q <= opt_wake_off;
        pull_off_q <= opt_pull_off;
        tsrc_q     <= opt_tsrc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      snap    <= '0;
      sleep_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      sync1   <= pin_in;
      sync2   <= sync1;
      sleep_q <= sleep;
      if (sleep && !sleep_q) snap <= sync2;
      seen_q  <= sleep ? (seen_q | diff) : 1'b0;
    end
  end

  assign pin_oe    = ~dir_q & ~(tsrc_q ? FORCE : '0);
  assign pin_pu_en = MASK & dir_q & {N{~pull_off_q}};
  assign wk_en     = MASK & dir_q & {N{~wake_off_q}};
  assign diff      = sleep && sleep_q && (|((sync2 ^ snap) & wk_en));
  assign wake      = diff && !seen_q;

  a_r3_timer_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_we && opt_tsrc) |=> !pin_oe[TMR_PIN]);
  a_r5_output_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> ((pin_pu_en & ~$past(dir_wdata)) == '0));
  a_r5_oe_pu_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu_en) == '0);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  a_r9_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |-> !wake);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_we && opt_wake_off) |=> !wake);

endmodule

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       dir_we = 0, opt_we = 0, opt_wake_off = 1, opt_pull_off = 1, opt_tsrc = 1, sleep = 0;
  logic [5:0] dir_wdata = '1, pin_in = '0;
  logic [5:0] pin_oe, pin_pu_en;
  logic       wake;
  int         n_chk = 0, n_bad = 0;
  localparam logic [5:0] M = 6'b001011;

  always #4 clk = ~clk;

  gpio_wake_port u0 (.clk, .rst_n, .dir_we, .dir_wdata, .opt_we, .opt_wake_off,
    .opt_pull_off, .opt_tsrc, .sleep, .pin_in, .pin_oe, .pin_pu_en, .wake);

  task automatic step(); @(posedge clk); #2; endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg(logic [5:0] d, logic wo, logic po, logic ts);
    dir_we = 1; dir_wdata = d; opt_we = 1;
    opt_wake_off = wo; opt_pull_off = po; opt_tsrc = ts;
    step();
    dir_we = 0; opt_we = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    step(); step();
    rst_n = 1; step();
    chk("R1 oe", pin_oe, 6'b0);
    chk("R1 pu", pin_pu_en, 6'b0);
    chk("R1 wake", {5'b0, wake}, 6'b0);

    for (int d = 0; d < 64; d++)
      for (int po = 0; po < 2; po++)
        for (int ts = 0; ts < 2; ts++) begin
          cfg(d[5:0], 1'b1, po[0], ts[0]);
          chk(ts ? "R3 oe forced" : "R2 oe", pin_oe, ~d[5:0] & ~(ts ? 6'b000100 : 6'b0));
          chk("R4 R5 pu", pin_pu_en, po ? 6'b0 : (d[5:0] & M));
        end

    for (int p = 0; p < 6; p++)
      for (int wo = 0; wo < 2; wo++)
        for (int dv = 0; dv < 2; dv++) begin
          logic [5:0] d;
          logic exp;
          d = 6'b111111;
          d[p] = dv[0];
          exp = M[p] & dv[0] & ~wo[0];
          cfg(d, wo[0], 1'b1, 1'b0);
          pin_in = '0; step(); step(); step();
          pin_in[p] = 1'b1; step(); step();
          chk("R9 awake", {5'b0, wake}, 6'b0);
          pin_in = '0; step(); step(); step();
          sleep = 1; step(); step();
          pin_in[p] = 1'b1; step();
          chk("R6 sync latency", {5'b0, wake}, 6'b0);
          step();
          chk(exp ? "R6 wake" : "R8 R5 no wake", {5'b0, wake}, {5'b0, exp});
          step();
          chk("R7 pulse end", {5'b0, wake}, 6'b0);
          sleep = 0; pin_in = '0; step(); step(); step();
        end

    cfg(6'b111111, 1'b0, 1'b1, 1'b0);
    pin_in = '0; step(); step(); step();
    sleep = 1; step(); step();
    pin_in[0] = 1; step(); step();
    chk("R7 first", {5'b0, wake}, 6'b1);
    step(); step();
    pin_in[1] = 1; step(); step();
    chk("R7 no second", {5'b0, wake}, 6'b0);
    step();
    chk("R7 still quiet", {5'b0, wake}, 6'b0);
    sleep = 0; step(); step();
    sleep = 1; step(); step();
    pin_in[3] = 1; step(); step();
    chk("R7 rearmed", {5'b0, wake}, 6'b1);
    sleep = 0; step();

    summary();
  end
endmodule